// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for each beat of one SDRAM read or write burst. A command strobe loads the start column, the burst length code, the beat order and the transfer direction. From the next cycle on, the block presents one column per clock, together with a beat-valid flag and a flag that marks the final beat. A new command replaces the running burst on the very next clock.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block of the start column. The beats run either in counting order or in XOR order. In full-page mode the column steps through all 512 columns, wraps to the start and keeps running until a stop request. A stop request during any other burst, or with no burst running, raises an illegal flag and has no other effect. For reads, a delayed copy of the beat-valid flag marks when read data is due, 2 or 3 clocks after the command.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset, and with no command issued, beat_valid, burst_done and rd_valid are all 0.
- R2: The length code len sets the beat count: 3'b000=1, 3'b001=2, 3'b010=4, 3'b011=8, 3'b111=full page, and the codes 3'b100 to 3'b110 give 1 beat. The first beat, at the start column, is shown in the cycle after the cycle in which start is high. Further beats follow with no gap.
- R3: With interleave=0 and a fixed length N, beat i shows column (start_col - start_col mod N) + ((start_col mod N + i) mod N).
- R4: With interleave=1 and a fixed length N, beat i shows column start_col XOR i.
- R5: burst_done is 1 exactly on the final beat of a fixed-length burst. beat_valid is 0 in the cycle after that beat unless a new command was issued.
- R6: In full-page mode, beat i shows column (start_col + i) mod 512 for as long as the burst runs. The interleave input is ignored and burst_done stays 0.
- R7: A stop request sampled during a full-page burst ends it: beat_valid is 0 in the next cycle, and stop_illegal stays 0.
- R8: A stop request while no full-page burst is running drives stop_illegal to 1 in that same cycle and leaves the running burst unchanged.
- R9: A write command with single_write=1 produces exactly one beat at start_col, with burst_done set, whatever the length code.
- R10: A command issued during a running burst ends that burst. The next cycle shows beat 0 of the new burst.
- R11: For a read command (is_write=0), rd_valid is 1 for every beat, starting 2 clocks after the command when cl3=0 and 3 clocks after it when cl3=1. rd_valid stays 0 for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Read or write command strobe |
| is_write | input | 1 | 1 for a write command, 0 for a read |
| start_col | input | COL_W | Start column of the burst |
| len | input | 3 | Burst length code |
| interleave | input | 1 | 1 selects XOR beat order |
| single_write | input | 1 | Writes touch a single column |
| stop | input | 1 | Burst stop request |
| cl3 | input | 1 | CAS latency: 0 for 2 clocks, 1 for 3 clocks |
| col | output | COL_W | Column of the current beat |
| beat_valid | output | 1 | A beat is shown this cycle |
| burst_done | output | 1 | The current beat is the last of a fixed burst |
| stop_illegal | output | 1 | The stop request is illegal in this cycle |
| rd_valid | output | 1 | Read data is due this cycle |

## Verification
col, beat_valid and burst_done come from one register stage, so they are due one clock after the command edge. stop_illegal is combinational and is due in the same cycle as the stop request. rd_valid is due 2 or 3 clocks after the command. The bench drives every input on the falling edge and reads every result on a later falling edge, counting the clocks from the command or the stop request. It counts the falling edges between the command and each rd_valid check, and the restart and stop tests check the very first cycle after the request.

// File: rtl/sdram_col_seq.sv
`timescale 1ns/1ps
module sdram_col_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_write,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len,
  input  logic             interleave,
  input  logic             single_write,
  input  logic             stop,
  input  logic             cl3,
  output logic [COL_W-1:0] col,
  output logic             beat_valid,
  output logic             burst_done,
  output logic             stop_illegal,
  output logic             rd_valid
);
  localparam logic [COL_W-1:0] FULL = {COL_W{1'b1}};

  logic             act, fp, ilv, rd;
  logic [COL_W-1:0] cnt, base, mask, ld_mask;
  logic [1:0]       rv;
  logic             last, ld_fp;

  always_comb begin
    ld_fp = 1'b0;
    case (len)
      3'b001:  ld_mask = COL_W'(1);
      3'b010:  ld_mask = COL_W'(3);
      3'b011:  ld_mask = COL_W'(7);
      3'b111:  begin ld_mask = FULL; ld_fp = 1'b1; end
      default: ld_mask = '0;
    endcase
    if (is_write && single_write) begin
      ld_mask = '0;
      ld_fp   = 1'b0;
    end
  end

  assign last = (cnt == mask) && !fp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      fp   <= 1'b0;
      ilv  <= 1'b0;
      rd   <= 1'b0;
      cnt  <= '0;
      base <= '0;
      mask <= '0;
      rv   <= '0;
    end else begin
      rv <= {rv[0], act & rd};
      if (start) begin
        act  <= 1'b1;
        cnt  <= '0;
        base <= start_col;
        mask <= ld_mask;
        fp   <= ld_fp;
        ilv  <= interleave & ~ld_fp;
        rd   <= ~is_write;
      end else if (act) begin
        if ((fp && stop) || last) act <= 1'b0;
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign col          = ilv ? (base ^ (cnt & mask))
                            : ((base & ~mask) | ((base + cnt) & mask));
  assign beat_valid   = act;
  assign burst_done   = act & last;
  assign stop_illegal = stop & ~(act & fp);
  assign rd_valid     = cl3 ? rv[1] : rv[0];

  // R5
  done_has_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> beat_valid);
  // R5
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && !start) |=> !beat_valid);
  // R6
  fp_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && fp) |-> !burst_done);
  // R7
  fp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && fp && stop && !start) |=> !beat_valid);
  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (beat_valid && col == $past(start_col)));
  // R9
  single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && is_write && single_write) |=> burst_done);
  // R11
  rd_cl2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !cl3 && !$changed(cl3)) |-> $past(act && rd));
endmodule

// File: tb/tb_sdram_col_seq.sv
`timescale 1ns/1ps
module tb_sdram_col_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, is_write = 0, interleave = 0, single_write = 0, stop = 0, cl3 = 0;
  logic [8:0] start_col = '0;
  logic [2:0] len = '0;
  logic [8:0] col;
  logic beat_valid, burst_done, stop_illegal, rd_valid;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  sdram_col_seq dut (.clk, .rst_n, .start, .is_write, .start_col, .len, .interleave,
    .single_write, .stop, .cl3, .col, .beat_valid, .burst_done, .stop_illegal, .rd_valid);

  // {start_col[14:6], len[5:3], ilv[2], wr[1], sw[0]}
  localparam int NV = 10;
  localparam logic [14:0] VEC [NV] = '{
    {9'd6,   3'b010, 1'b0, 1'b0, 1'b0},
    {9'd13,  3'b011, 1'b0, 1'b0, 1'b0},
    {9'd13,  3'b011, 1'b1, 1'b0, 1'b0},
    {9'd510, 3'b010, 1'b1, 1'b1, 1'b0},
    {9'd511, 3'b001, 1'b0, 1'b0, 1'b0},
    {9'd77,  3'b000, 1'b0, 1'b0, 1'b0},
    {9'd200, 3'b101, 1'b0, 1'b1, 1'b0},
    {9'd42,  3'b011, 1'b0, 1'b1, 1'b1},
    {9'd42,  3'b011, 1'b0, 1'b1, 1'b0},
    {9'd250, 3'b011, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nbeats(input logic [2:0] l, input bit wr, input bit sw);
    if (wr && sw) return 1;
    case (l)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int c, input int n, input bit il, input int i);
    if (il) return c ^ i;
    return (c - c % n) + ((c % n + i) % n);
  endfunction

  task automatic issue(input int c, input logic [2:0] l, input bit il, input bit wr, input bit sw);
    start_col = 9'(c); len = l; interleave = il; is_write = wr; single_write = sw;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #1200000;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(beat_valid == 0, "R1 beat_valid", beat_valid, 0);
    chk(burst_done == 0, "R1 burst_done", burst_done, 0);
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(beat_valid == 0, "R1 idle", beat_valid, 0);

    // R2 R3 R4 R5 R9 vectors
    for (int v = 0; v < NV; v++) begin
      int c, n;
      bit il;
      c = int'(VEC[v][14:6]);
      n = nbeats(VEC[v][5:3], VEC[v][1], VEC[v][0]);
      il = VEC[v][2];
      @(negedge clk);
      issue(c, VEC[v][5:3], il, VEC[v][1], VEC[v][0]);
      for (int i = 0; i < n; i++) begin
        chk(beat_valid == 1, il ? "R4 valid" : "R3 valid", beat_valid, 1);
        chk(col == 9'(exp_col(c, n, il, i)), il ? "R4 col" : "R3 col", col, exp_col(c, n, il, i));
        chk(burst_done == (i == n - 1), "R5 done", burst_done, i == n - 1);
        @(negedge clk);
      end
      chk(beat_valid == 0, "R2 count", beat_valid, 0);
    end

    // R6 R7 full page, interleave ignored
    @(negedge clk);
    issue(510, 3'b111, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 600; i++) begin
      chk(col == 9'((510 + i) % 512) && beat_valid, "R6 col", col, (510 + i) % 512);
      chk(burst_done == 0, "R6 done", burst_done, 0);
      if (i == 599) begin
        stop = 1'b1;
        #1;
        chk(stop_illegal == 0, "R7 legal", stop_illegal, 0);
      end
      @(negedge clk);
    end
    stop = 1'b0;
    chk(beat_valid == 0, "R7 stopped", beat_valid, 0);

    // R8 illegal stop
    stop = 1'b1;
    #1;
    chk(stop_illegal == 1, "R8 idle", stop_illegal, 1);
    @(negedge clk);
    stop = 1'b0;
    issue(16, 3'b011, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      if (i == 2) begin
        stop = 1'b1;
        #1;
        chk(stop_illegal == 1, "R8 flag", stop_illegal, 1);
      end
      chk(col == 9'(16 + i) && beat_valid, "R8 col", col, 16 + i);
      chk(burst_done == (i == 7), "R8 done", burst_done, i == 7);
      @(negedge clk);
      stop = 1'b0;
    end
    chk(beat_valid == 0, "R8 end", beat_valid, 0);

    // R10 restart
    issue(0, 3'b011, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(col == 9'd3, "R10 before", col, 3);
    issue(100, 3'b010, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      chk(col == 9'(100 + i) && beat_valid, "R10 col", col, 100 + i);
      chk(burst_done == (i == 3), "R10 done", burst_done, i == 3);
      @(negedge clk);
    end
    chk(beat_valid == 0, "R10 end", beat_valid, 0);

    // R11 read latency
    for (int lat = 2; lat <= 3; lat++) begin
      repeat (4) @(negedge clk);
      cl3 = (lat == 3);
      issue(8, 3'b010, 1'b0, 1'b0, 1'b0);
      for (int k = 1; k <= 8; k++) begin
        chk(rd_valid == (k >= lat && k < lat + 4), "R11 rd", rd_valid, k >= lat && k < lat + 4);
        @(negedge clk);
      end
    end
    issue(8, 3'b010, 1'b0, 1'b1, 1'b0);
    for (int k = 1; k <= 6; k++) begin
      chk(rd_valid == 0, "R11 write", rd_valid, 0);
      @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule